// File: doc/BRIEF.md
# Exception Capture and Privilege Control Registers

This block is the small register set a 32-bit load/store core uses to record what went wrong and where. On each exception it captures the program counter of the offending instruction, the cause code and, when present, the faulting data address. It then drops the core into kernel mode with interrupts disabled and tells the fetch stage to jump to a fixed handler address. A return strobe undoes the entry: the saved privilege and enable state comes back, and fetch is sent to the saved program counter.

The registers are reached by number through a read port and a write port, as the core's move-to and move-from instructions would use them. Number 8 is the fault address, 12 is status, 13 is cause and 14 is the saved exception PC. Six external interrupt lines and two software interrupt bits are gated by a mask and a global enable to form one pending-interrupt output. Address translation and pipeline flushing stay outside the block.

Top module: `exc_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, registers 8, 12, 13 and 14 read 0. The mode output is 0 (kernel, since 1 means user), and neither the pending output nor the redirect output is asserted.
- R2: On an exception request, from the next cycle on: register 14 holds the request's PC, cause bits 5:2 hold the 4-bit code, and the mode is kernel with the global enable (status bit 0) cleared. For that one cycle, redirect is high with the handler vector 0x0000_0100.
- R3: Register 8 loads the faulting address only when an exception request comes with its address-valid flag set. Otherwise it keeps its value, and software writes to it have no effect.
- R4: Status bits 5:0 form a three-level stack of {mode, enable} pairs: bit 1 is mode and bit 0 is enable for the current level. Exception entry shifts the stack up by one level (bits 1:0 to 3:2, and 3:2 to 5:4), discards the oldest level and loads {kernel, disabled} into bits 1:0.
- R5: A return strobe shifts the stack down by one level and fills bits 5:4 with 0. For one cycle, redirect is high with the value register 14 held when the strobe arrived.
- R6: If an exception request and a return strobe arrive in the same cycle, the exception is taken and the return is ignored.
- R7: Software writes to register 13 change only bits 9:8 (the software interrupt bits). The code field and the hardware interrupt field are unaffected by such writes.
- R8: Cause bits 15:10 show the six interrupt lines as sampled at the previous clock edge.
- R9: The pending output is high exactly when status bit 0 is set and at least one cause bit in 15:8 is set together with the same status bit in 15:8 (the mask).
- R10: Status is writable in bits 15:8 and 5:0, and its other bits read 0. Reads of any number other than 8, 12, 13 and 14 return 0, and writes to such numbers are ignored.
- R11: A software write in the same cycle as an exception request is dropped for status, cause and register 14. The hardware update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | 1 | Exception request, one cycle |
| exc_code_i | input | 4 | Exception code |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| exc_addr_valid_i | input | 1 | Faulting data address is valid |
| exc_addr_i | input | 32 | Faulting data address |
| irq_i | input | 6 | External interrupt lines |
| eret_i | input | 1 | Return-from-exception strobe |
| sw_wr_i | input | 1 | Software register write enable |
| sw_num_i | input | 5 | Register number to write |
| sw_wdata_i | input | 32 | Write data |
| sw_rnum_i | input | 5 | Register number to read |
| sw_rdata_o | output | 32 | Read data |
| user_mode_o | output | 1 | Current mode, 1 = user, 0 = kernel |
| irq_pending_o | output | 1 | Enabled interrupt pending |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |

## Verification
The bench uses the default parameters: six hardware lines, two software bits and a three-level stack. With six lines, all 64 interrupt patterns can be swept. Each pattern is paired with its own mask and both enable settings, and the pending output is predicted arithmetically. All sixteen exception codes are each sent through an entry and a return. The three-level depth lets four nested entries show the oldest level being discarded.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception register set.
// Assumes a 32-bit datapath and a 5-bit register number.
package exc_pkg;
    localparam int XLEN = 32;
    localparam logic [4:0] NUM_BADADDR = 5'd8;
    localparam logic [4:0] NUM_STATUS  = 5'd12;
    localparam logic [4:0] NUM_CAUSE   = 5'd13;
    localparam logic [4:0] NUM_EPC     = 5'd14;
    localparam int CODE_LSB = 2;
    localparam int CODE_W   = 4;

    // One stack level: mode (1 = user) above enable.
    typedef struct packed {
        logic mode;
        logic ie;
    } priv_lvl_t;
endpackage

// File: rtl/exc_priv_stack.sv
// Status register: interrupt mask plus a shift stack of {mode, enable}.
// Assumes push and pop are never both asserted (the top resolves that).
// Priority inside: push, then pop, then software write.
module exc_priv_stack
    import exc_pkg::*;
#(
    parameter int DEPTH    = 3,
    parameter int MASK_W   = 8,
    parameter int MASK_LSB = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic            wr_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] status_o,
    output logic            mode_o,
    output logic            ie_o,
    output logic [MASK_W-1:0] mask_o
);
    localparam int STK_W = 2 * DEPTH;

    logic [STK_W-1:0]  stk_q;
    logic [MASK_W-1:0] mask_q;
    priv_lvl_t         cur;

    // Stack and mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q  <= '0;
            mask_q <= '0;
        end else if (push_i) begin
            stk_q <= {stk_q[STK_W-3:0], 2'b00};
        end else if (pop_i) begin
            stk_q <= {2'b00, stk_q[STK_W-1:2]};
        end else if (wr_i) begin
            stk_q  <= wdata_i[STK_W-1:0];
            mask_q <= wdata_i[MASK_LSB +: MASK_W];
        end
    end

    // Assemble the architectural view.
    always_comb begin
        status_o = '0;
        status_o[STK_W-1:0] = stk_q;
        status_o[MASK_LSB +: MASK_W] = mask_q;
    end

    assign cur    = priv_lvl_t'(stk_q[1:0]);
    assign mode_o = cur.mode;
    assign ie_o   = cur.ie;
    assign mask_o = mask_q;

    AST_PUSH_SAVES_PREV: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> stk_q[3:2] == $past(stk_q[1:0])); // R4
    AST_PUSH_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> !mode_o && !ie_o); // R2
    AST_POP_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> stk_q[1:0] == $past(stk_q[3:2])); // R5
endmodule

// File: rtl/exc_cause_reg.sv
// Cause register: sampled interrupt lines, software interrupt bits and
// the exception code. Only the software bits take software writes.
module exc_cause_reg
    import exc_pkg::*;
#(
    parameter int HW_IRQ = 6,
    parameter int SW_IRQ = 2,
    parameter int SW_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HW_IRQ-1:0] irq_i,
    input  logic              exc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              wr_i,
    input  logic [XLEN-1:0]   wdata_i,
    output logic [XLEN-1:0]   cause_o
);
    localparam int HW_LSB = SW_LSB + SW_IRQ;

    logic [HW_IRQ-1:0] hw_q;
    logic [SW_IRQ-1:0] sw_q;
    logic [CODE_W-1:0] code_q;

    // Interrupt line sampling every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= '0;
        else        hw_q <= irq_i;
    end

    // Code on exception; software bits on a write outside an exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            sw_q   <= '0;
        end else if (exc_i) begin
            code_q <= code_i;
        end else if (wr_i) begin
            sw_q <= wdata_i[SW_LSB +: SW_IRQ];
        end
    end

    always_comb begin
        cause_o = '0;
        cause_o[HW_LSB +: HW_IRQ]   = hw_q;
        cause_o[SW_LSB +: SW_IRQ]   = sw_q;
        cause_o[CODE_LSB +: CODE_W] = code_q;
    end

    AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cause_o[HW_LSB +: HW_IRQ] == $past(irq_i)); // R8
    AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> cause_o[CODE_LSB +: CODE_W] == $past(code_i)); // R2
    AST_CODE_SW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_i |=> $stable(cause_o[CODE_LSB +: CODE_W])); // R7
endmodule

// File: rtl/exc_capture.sv
// Saved exception PC and faulting address. The saved PC takes software
// writes; the fault address is loaded by hardware only.
module exc_capture
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            addr_valid_i,
    input  logic [XLEN-1:0] addr_i,
    input  logic            epc_wr_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] badaddr_o
);
    // Saved PC: hardware capture beats a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        epc_o <= '0;
        else if (exc_i)    epc_o <= pc_i;
        else if (epc_wr_i) epc_o <= wdata_i;
    end

    // Fault address: only on an exception carrying an address.
    always_ff @(posedge clk) begin
        if (!rst_n)                    badaddr_o <= '0;
        else if (exc_i && addr_valid_i) badaddr_o <= addr_i;
    end

    AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> epc_o == $past(pc_i)); // R2
    AST_BADADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_i && addr_valid_i) |=> $stable(badaddr_o)); // R3
endmodule

// File: rtl/exc_ctrl_regs.sv
// Exception register set top: number decode, read mux, interrupt gating
// and the fetch redirect. Assumes exc_req_i and eret_i are one-cycle
// strobes from the retire stage; an exception outranks a return.
module exc_ctrl_regs
    import exc_pkg::*;
#(
    parameter int          HW_IRQ      = 6,
    parameter int          SW_IRQ      = 2,
    parameter int          STK_DEPTH   = 3,
    parameter logic [31:0] HANDLER_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req_i,
    input  logic [3:0]        exc_code_i,
    input  logic [31:0]       exc_pc_i,
    input  logic              exc_addr_valid_i,
    input  logic [31:0]       exc_addr_i,
    input  logic [HW_IRQ-1:0] irq_i,
    input  logic              eret_i,
    input  logic              sw_wr_i,
    input  logic [4:0]        sw_num_i,
    input  logic [31:0]       sw_wdata_i,
    input  logic [4:0]        sw_rnum_i,
    output logic [31:0]       sw_rdata_o,
    output logic              user_mode_o,
    output logic              irq_pending_o,
    output logic              redirect_o,
    output logic [31:0]       redirect_pc_o
);
    localparam int SW_LSB = 8;
    localparam int MASK_W = HW_IRQ + SW_IRQ;

    logic [XLEN-1:0]   status, cause, epc, badaddr;
    logic [MASK_W-1:0] mask;
    logic              ie;
    logic              eret_eff;
    logic              wr_status, wr_cause, wr_epc;

    assign eret_eff  = eret_i && !exc_req_i;
    assign wr_status = sw_wr_i && (sw_num_i == NUM_STATUS);
    assign wr_cause  = sw_wr_i && (sw_num_i == NUM_CAUSE);
    assign wr_epc    = sw_wr_i && (sw_num_i == NUM_EPC);

    exc_priv_stack #(.DEPTH(STK_DEPTH), .MASK_W(MASK_W), .MASK_LSB(SW_LSB)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_i(exc_req_i), .pop_i(eret_eff),
        .wr_i(wr_status), .wdata_i(sw_wdata_i), .status_o(status),
        .mode_o(user_mode_o), .ie_o(ie), .mask_o(mask)
    );

    exc_cause_reg #(.HW_IRQ(HW_IRQ), .SW_IRQ(SW_IRQ), .SW_LSB(SW_LSB)) u_cause (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .exc_i(exc_req_i),
        .code_i(exc_code_i), .wr_i(wr_cause), .wdata_i(sw_wdata_i), .cause_o(cause)
    );

    exc_capture u_capture (
        .clk(clk), .rst_n(rst_n), .exc_i(exc_req_i), .pc_i(exc_pc_i),
        .addr_valid_i(exc_addr_valid_i), .addr_i(exc_addr_i),
        .epc_wr_i(wr_epc), .wdata_i(sw_wdata_i), .epc_o(epc), .badaddr_o(badaddr)
    );

    // Read mux by register number; unmapped numbers return zero.
    always_comb begin
        unique case (sw_rnum_i)
            NUM_BADADDR: sw_rdata_o = badaddr;
            NUM_STATUS:  sw_rdata_o = status;
            NUM_CAUSE:   sw_rdata_o = cause;
            NUM_EPC:     sw_rdata_o = epc;
            default:     sw_rdata_o = '0;
        endcase
    end

    // Pending interrupt: any unmasked source while globally enabled.
    assign irq_pending_o = ie && |(cause[SW_LSB +: MASK_W] & mask);

    // Fetch redirect: handler on entry, saved PC on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
        end else begin
            redirect_o    <= exc_req_i || eret_eff;
            redirect_pc_o <= exc_req_i ? HANDLER_VEC : epc;
        end
    end

    AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i |=> redirect_o && redirect_pc_o == HANDLER_VEC); // R2
    AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !exc_req_i) |=> redirect_o && redirect_pc_o == $past(epc)); // R5
    AST_ENTRY_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i |=> !irq_pending_o); // R9
    AST_EXC_BEATS_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_i && eret_i) |=> !user_mode_o); // R6
endmodule

// File: tb/exc_ctrl_regs_bench.sv
module exc_ctrl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic        exc_av = 1'b0;
    logic [31:0] exc_addr = '0;
    logic [5:0]  irq = '0;
    logic        eret = 1'b0;
    logic        sw_wr = 1'b0;
    logic [4:0]  sw_num = '0;
    logic [31:0] sw_wdata = '0;
    logic [4:0]  sw_rnum = '0;
    logic [31:0] sw_rdata;
    logic        user_mode, pending, redirect;
    logic [31:0] redirect_pc;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_bad;
    logic [3:0]  last_code;

    localparam logic [31:0] VEC = 32'h0000_0100;

    always #10 clk = ~clk;

    exc_ctrl_regs u_exc_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_code_i(exc_code),
        .exc_pc_i(exc_pc), .exc_addr_valid_i(exc_av), .exc_addr_i(exc_addr),
        .irq_i(irq), .eret_i(eret), .sw_wr_i(sw_wr), .sw_num_i(sw_num),
        .sw_wdata_i(sw_wdata), .sw_rnum_i(sw_rnum), .sw_rdata_o(sw_rdata),
        .user_mode_o(user_mode), .irq_pending_o(pending),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [4:0] num, input logic [31:0] exp);
        sw_rnum = num;
        #1;
        check(req, sw_rdata, exp);
    endtask

    task automatic sw_write(input logic [4:0] num, input logic [31:0] data);
        sw_wr = 1'b1; sw_num = num; sw_wdata = data;
        tick();
        sw_wr = 1'b0;
    endtask

    task automatic raise(input logic [3:0] code, input logic [31:0] pc,
                         input logic av, input logic [31:0] addr);
        exc_req = 1'b1; exc_code = code; exc_pc = pc; exc_av = av; exc_addr = addr;
        tick();
        exc_req = 1'b0; exc_av = 1'b0;
        if (av) exp_bad = addr;
        last_code = code;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        exp_bad = '0;
        last_code = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check_reg("R1 badaddr", 5'd8, 32'h0);
        check_reg("R1 status", 5'd12, 32'h0);
        check_reg("R1 cause", 5'd13, 32'h0);
        check_reg("R1 epc", 5'd14, 32'h0);
        check("R1 mode", {31'b0, user_mode}, 32'h0);
        check("R1 pending", {31'b0, pending}, 32'h0);
        check("R1 redirect", {31'b0, redirect}, 32'h0);

        // R10 status writable fields
        sw_write(5'd12, 32'hFFFF_FFFF);
        check_reg("R10 status mask", 5'd12, 32'h0000_FF3F);
        check("R10 mode user", {31'b0, user_mode}, 32'h1);

        // R2 R3 R5: every exception code through entry and return
        for (int c = 0; c < 16; c++) begin
            sw_write(5'd12, 32'h0000_0003);
            raise(c[3:0], 32'h0000_1000 + 32'(c) * 4, c[0], 32'h0000_A000 + 32'(c));
            check("R2 mode kernel", {31'b0, user_mode}, 32'h0);
            check("R2 redirect", {31'b0, redirect}, 32'h1);
            check("R2 vector", redirect_pc, VEC);
            check_reg("R2 epc", 5'd14, 32'h0000_1000 + 32'(c) * 4);
            check_reg("R2 code", 5'd13, 32'(c) << 2);
            check_reg("R4 status push", 5'd12, 32'h0000_000C);
            check_reg("R3 badaddr", 5'd8, exp_bad);
            eret = 1'b1;
            tick();
            eret = 1'b0;
            check("R5 mode restored", {31'b0, user_mode}, 32'h1);
            check_reg("R5 status pop", 5'd12, 32'h0000_0003);
            check("R5 redirect", {31'b0, redirect}, 32'h1);
            check("R5 target", redirect_pc, 32'h0000_1000 + 32'(c) * 4);
            tick();
            check("R5 redirect pulse", {31'b0, redirect}, 32'h0);
        end

        // R4 nesting: oldest level discarded
        sw_write(5'd12, 32'h0000_0003);
        raise(4'd1, 32'h100, 1'b0, 32'h0);
        raise(4'd2, 32'h104, 1'b0, 32'h0);
        check_reg("R4 two deep", 5'd12, 32'h0000_0030);
        eret = 1'b1; tick(); eret = 1'b0;
        check_reg("R4 one pop", 5'd12, 32'h0000_000C);
        raise(4'd3, 32'h108, 1'b0, 32'h0);
        raise(4'd4, 32'h10C, 1'b0, 32'h0);
        raise(4'd5, 32'h110, 1'b0, 32'h0);
        check_reg("R4 oldest lost", 5'd12, 32'h0000_0000);

        // R6 simultaneous exception and return
        sw_write(5'd12, 32'h0000_0003);
        exc_req = 1'b1; eret = 1'b1; exc_code = 4'd9; exc_pc = 32'h200;
        tick();
        exc_req = 1'b0; eret = 1'b0; last_code = 4'd9;
        check_reg("R6 pushed", 5'd12, 32'h0000_000C);
        check("R6 vector", redirect_pc, VEC);

        // R7 cause writes touch only bits 9:8
        sw_write(5'd13, 32'hFFFF_FFFF);
        check_reg("R7 sw bits", 5'd13, (32'(last_code) << 2) | 32'h300);
        sw_write(5'd13, 32'h0);
        check_reg("R7 cleared", 5'd13, 32'(last_code) << 2);

        // R8 R9 sweep of all line patterns, mask and enable
        for (int p = 0; p < 64; p++) begin
            for (int e = 0; e < 2; e++) begin
                logic [7:0] m;
                m = 8'((p * 37 + e * 11) & 8'hFF);
                irq = p[5:0];
                sw_write(5'd12, {16'h0, m, 8'(e)});
                check_reg("R8 lines", 5'd13, (32'(p) << 10) | (32'(last_code) << 2));
                check("R9 pending", {31'b0, pending},
                      {31'b0, (e == 1) && ((8'(p << 2) & m) != 8'h0)});
            end
        end
        irq = '0;
        sw_write(5'd13, 32'h0000_0100);
        sw_write(5'd12, 32'h0000_0101);
        check("R9 software source", {31'b0, pending}, 32'h1);
        sw_write(5'd12, 32'h0000_0200);
        check("R9 unmasked off", {31'b0, pending}, 32'h0);

        // R10 R3 unmapped and read-only numbers
        sw_write(5'd12, 32'h0000_0003);
        sw_write(5'd5, 32'hFFFF_FFFF);
        sw_write(5'd8, 32'h1234_5678);
        check_reg("R10 unmapped read", 5'd5, 32'h0);
        check_reg("R10 status kept", 5'd12, 32'h0000_0003);
        check_reg("R3 no sw write", 5'd8, exp_bad);

        // R11 hardware beats software in the same cycle
        exc_req = 1'b1; exc_code = 4'd6; exc_pc = 32'h300;
        sw_wr = 1'b1; sw_num = 5'd12; sw_wdata = 32'h0000_FF00;
        tick();
        exc_req = 1'b0; sw_wr = 1'b0; last_code = 4'd6;
        check_reg("R11 status", 5'd12, 32'h0000_000C);
        exc_req = 1'b1; exc_code = 4'd7; exc_pc = 32'h304;
        sw_wr = 1'b1; sw_num = 5'd14; sw_wdata = 32'hDEAD_0000;
        tick();
        exc_req = 1'b0; sw_wr = 1'b0;
        check_reg("R11 epc", 5'd14, 32'h304);
        sw_write(5'd14, 32'h0000_4444);
        eret = 1'b1; tick(); eret = 1'b0;
        check("R5 written epc target", redirect_pc, 32'h0000_4444);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule